// File: doc/BRIEF.md
# Rate-Matching Delayed Buffer

The buffer takes short, irregular bursts in which several elements arrive side by side in one cycle. It plays them back one element at a time at a fixed pace. A repeating schedule of `PERIOD` enabled cycles is split into `TOTAL` equal output slots, one every `STRIDE = PERIOD / TOTAL` enabled cycles. A producer normally writes early in each period, and the consumer sees an even stream with a qualifying `valid`. Writes for the next period can arrive while the current contents are still draining.

Storage is a small ring of `DEPTH` elements, arranged as rows of `LANES` elements so that one write fills a whole row. When a slot falls while the buffer is empty and a write arrives in that same cycle, the first lane of that write goes straight through to the output. The producer can therefore write and emit in the same cycle at the start of a period. A clock enable freezes the whole block. Elaboration stops with an error if `TOTAL` does not divide `PERIOD`, if `LANES` does not divide `TOTAL`, or if `LANES` or `DEPTH` is not a power of two.

Top module: `rate_match_buffer`

## Requirements
- R1: `rst` is synchronous and active high. While it is high, `valid` is low. After it is released the buffer is empty and the slot schedule restarts.
- R2: The first enabled cycle after reset is a slot, and further slots follow every `STRIDE` enabled cycles. `valid` is never high outside a slot cycle.
- R3: A cycle with `ce` and `we` high and room in the buffer stores all `LANES` elements of `din` at once. Lane k sits in bits [k*W +: W], and lane 0 is queued first.
- R4: In a slot cycle with stored data, `valid` is high and `dout` carries the oldest stored element, which is then removed. Elements leave in the order they were queued.
- R5: In a slot cycle where the buffer is empty and an accepted write arrives, `valid` is high in that same cycle and `dout` equals lane 0 of `din`. The remaining lanes stay queued.
- R6: If exactly `TOTAL` elements are written in every period, `valid` is high exactly `TOTAL` times per period, period after period.
- R7: While `ce` is low, `valid` is low, `we` is ignored, and neither the schedule nor the stored contents change.
- R8: A write is dropped entirely when fewer than `LANES` places are free, that is, when occupancy exceeds `DEPTH - LANES`. It is judged on the occupancy at the start of the cycle.
- R9: In a slot cycle with an empty buffer and no accepted write, `valid` stays low and nothing is consumed. The next slot still comes `STRIDE` enabled cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable for all state and for output qualification |
| we | input | 1 | Write request for the whole lane vector |
| din | input | LANES*W | Parallel input elements, lane 0 in the low bits |
| dout | output | W | Emitted element, meaningful when `valid` is high |
| valid | output | 1 | High in a slot cycle that emits an element |

## Verification
In one cycle the buffer can accept a burst and emit an element. The hardest case is a slot that meets an empty buffer and a write together, where the output must come from the input and the rest of the burst must still queue behind it. Two other collisions also matter: a write offered to a nearly full ring in the same cycle as a read, and a clock enable that drops in the middle of this activity. The bench produces these with fixed period patterns, long write floods and idle stretches, a toggling enable, and a long run of random enable and write settings. In every cycle it compares `valid`, and `dout` whenever an element is due, against a queue model that pushes accepted bursts and pops on slots.

// File: rtl/rmb_pkg.sv
package rmb_pkg;
  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

  function automatic bit divides(input int d, input int n);
    return (d > 0) && ((n % d) == 0);
  endfunction
endpackage

// File: rtl/rmb_slot_timer.sv
module rmb_slot_timer #(
  parameter int STRIDE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ce,
  output logic slot
);
  localparam int PW = (STRIDE > 1) ? $clog2(STRIDE) : 1;
  localparam logic [PW-1:0] LAST = PW'(STRIDE - 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
    end else if (ce) begin
      if (phase == LAST) phase <= '0;
      else               phase <= phase + 1'b1;
    end
  end

  assign slot = (phase == '0);

  // R7: schedule frozen while disabled
  a_r7_timer_hold: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(phase));

  generate
    if (STRIDE > 1) begin : g_gap
      // R2: two enabled slots never sit back to back
      a_r2_slot_gap: assert property (@(posedge clk) disable iff (rst)
        (ce && slot) |=> !slot);
    end
  endgenerate
endmodule

// File: rtl/rmb_row_store.sv
module rmb_row_store #(
  parameter int W     = 8,
  parameter int LANES = 2,
  parameter int ROWS  = 4
) (
  input  logic                 clk,
  input  logic                 wen,
  input  logic [RW-1:0]        waddr,
  input  logic [LANES*W-1:0]   wdata,
  input  logic [RW-1:0]        raddr,
  output logic [LANES*W-1:0]   rdata
);
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;

  logic [LANES*W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (wen) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rmb_fifo_ctrl.sv
module rmb_fifo_ctrl #(
  parameter int LANES = 2,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic          we,
  input  logic          rd_fire,
  output logic          wr_ok,
  output logic          empty,
  output logic [RW-1:0] wr_row,
  output logic [RW-1:0] rd_row,
  output logic [LW-1:0] rd_lane,
  output logic [PW-1:0] occupancy
);
  localparam int ROWS = DEPTH / LANES;
  localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int IW   = $clog2(DEPTH);
  localparam int PW   = IW + 1;
  localparam int LB   = $clog2(LANES);
  localparam logic [PW-1:0] ROOM_MAX = PW'(DEPTH - LANES);

  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [IW-1:0] wr_idx, rd_idx;

  assign occupancy = wr_ptr - rd_ptr;
  assign empty     = (occupancy == '0);
  assign wr_ok     = ce && we && (occupancy <= ROOM_MAX);
  assign wr_idx    = wr_ptr[IW-1:0];
  assign rd_idx    = rd_ptr[IW-1:0];
  assign wr_row    = RW'(wr_idx >> LB);
  assign rd_row    = RW'(rd_idx >> LB);
  assign rd_lane   = LW'(rd_idx & IW'(LANES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (ce) begin
      if (wr_ok)   wr_ptr <= wr_ptr + PW'(LANES);
      if (rd_fire) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  // R8: ring never holds more than it has room for
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    occupancy <= PW'(DEPTH));
  // R3: an accepted write adds a full lane set at once
  a_r3_burst_adds: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && !rd_fire) |=> occupancy == $past(occupancy) + PW'(LANES));
  // R7: pointers frozen while disabled
  a_r7_ptr_hold: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(wr_ptr) && $stable(rd_ptr)));
endmodule

// File: rtl/rate_match_buffer.sv
module rate_match_buffer
  import rmb_pkg::*;
#(
  parameter int W      = 8,
  parameter int TOTAL  = 4,
  parameter int LANES  = 2,
  parameter int PERIOD = 16,
  parameter int DEPTH  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ce,
  input  logic               we,
  input  logic [LANES*W-1:0] din,
  output logic [W-1:0]       dout,
  output logic               valid
);
  localparam int STRIDE = PERIOD / TOTAL;
  localparam int ROWS   = DEPTH / LANES;
  localparam int RW     = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int LW     = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int PW     = $clog2(DEPTH) + 1;

  generate
    if (!divides(TOTAL, PERIOD) || !divides(LANES, TOTAL) ||
        !is_pow2(LANES) || !is_pow2(DEPTH) || (DEPTH < LANES)) begin : g_bad_cfg
      $error("rate_match_buffer: inconsistent size parameters");
    end
  endgenerate

  logic          slot, wr_ok, empty;
  logic [RW-1:0] wr_row, rd_row;
  logic [LW-1:0] rd_lane;
  logic [PW-1:0] occupancy;
  logic [LANES*W-1:0] row_data;
  logic [W-1:0]  lane_el [LANES];

  rmb_slot_timer #(.STRIDE(STRIDE)) u_timer (
    .clk(clk), .rst(rst), .ce(ce), .slot(slot)
  );

  rmb_fifo_ctrl #(.LANES(LANES), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .ce(ce), .we(we), .rd_fire(valid),
    .wr_ok(wr_ok), .empty(empty), .wr_row(wr_row), .rd_row(rd_row),
    .rd_lane(rd_lane), .occupancy(occupancy)
  );

  rmb_row_store #(.W(W), .LANES(LANES), .ROWS(ROWS)) u_store (
    .clk(clk), .wen(wr_ok), .waddr(wr_row), .wdata(din),
    .raddr(rd_row), .rdata(row_data)
  );

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign lane_el[k] = row_data[k*W +: W];
    end
  endgenerate

  assign valid = !rst && ce && slot && (!empty || wr_ok);
  assign dout  = empty ? din[W-1:0] : lane_el[rd_lane];

  // R9: an emission always has a source element
  a_r9_no_empty_read: assert property (@(posedge clk) disable iff (rst)
    valid |-> ((occupancy != '0) || (ce && we)));
  // R7: nothing is emitted while disabled
  a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !ce |-> !valid);
endmodule

// File: tb/rate_match_buffer_bench.sv
module rate_match_buffer_bench;
  localparam int W = 8, TOTAL = 4, LANES = 2, PERIOD = 16, DEPTH = 8;
  localparam int STRIDE = PERIOD / TOTAL;

  logic clk = 1'b0;
  logic rst = 1'b1, ce = 1'b0, we = 1'b0;
  logic [LANES*W-1:0] din = '0;
  logic [W-1:0] dout;
  logic valid;

  int total = 0, bad = 0, valid_seen = 0;
  int q[$];
  int phase = 0;
  int next_val = 1;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rate_match_buffer #(.W(W), .TOTAL(TOTAL), .LANES(LANES), .PERIOD(PERIOD), .DEPTH(DEPTH))
    u_rate_match_buffer (.clk(clk), .rst(rst), .ce(ce), .we(we), .din(din),
                         .dout(dout), .valid(valid));

  task automatic check(input string tag, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input bit r, input bit c, input bit w);
    bit slot, room, acc, ev;
    int ed;
    string tag;
    @(negedge clk);
    rst = r; ce = c; we = w;
    for (int k = 0; k < LANES; k++) din[k*W +: W] = W'(next_val + k);
    #1;
    slot = (phase == 0);
    room = (q.size() <= DEPTH - LANES);
    acc  = !r && c && w && room;
    ev   = !r && c && slot && (q.size() > 0 || acc);
    ed   = (q.size() > 0) ? q[0] : next_val;
    if (r) tag = "R1";
    else if (!c) tag = "R7";
    else if (slot && q.size() == 0 && acc) tag = "R5";
    else if (slot && q.size() == 0) tag = "R9";
    else if (w && !room) tag = "R8";
    else if (ev) tag = "R4";
    else if (acc) tag = "R3";
    else tag = "R2";
    check(tag, int'(valid), int'(ev), "valid");
    if (ev) begin
      check(tag, int'(dout), ed & ((1 << W) - 1), "dout");
      valid_seen++;
    end
    if (r) begin
      q.delete(); phase = 0;
    end else if (c) begin
      if (acc) for (int k = 0; k < LANES; k++) q.push_back((next_val + k) & ((1 << W) - 1));
      if (ev) void'(q.pop_front());
      phase = (phase + 1) % STRIDE;
    end
    if (w) next_val = (next_val + LANES) & ((1 << W) - 1);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset with enable and write active
    repeat (3) step(1'b1, 1'b1, 1'b1);
    // R6: steady periods, two bursts early in each
    valid_seen = 0;
    for (int p = 0; p < 4; p++)
      for (int c = 0; c < PERIOD; c++) step(1'b0, 1'b1, (c == 0 || c == 2));
    check("R6", valid_seen, 4 * TOTAL, "valids in four periods");
    // R7: toggling enable with writes on enabled cycles
    for (int i = 0; i < 200; i++) step(1'b0, (i % 2 == 0), (i % 8 == 0 || i % 8 == 3));
    // R8: flood of writes
    for (int i = 0; i < 30; i++) step(1'b0, 1'b1, 1'b1);
    // R9: drain and idle
    for (int i = 0; i < 50; i++) step(1'b0, 1'b1, 1'b0);
    // mid-run reset then random mix
    step(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 3000; i++)
      step(1'b0, ($urandom_range(0, 3) != 0), ($urandom_range(0, 4) == 0));
    for (int i = 0; i < 40; i++) step(1'b0, 1'b1, 1'b0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule